// File: doc/BRIEF.md
# Transition-Minimizing 8b/10b Video Channel Encoder

This block encodes one colour channel of a digital video link. Each accepted input beat is either a pixel byte or a two-bit control value, and it becomes one 10-bit line symbol. A pixel byte goes through two stages. The first stage folds the byte into a chained XOR or XNOR word that has few bit transitions. The second stage may complement the low eight bits of that word to pull a signed running disparity back toward zero. A control value bypasses both stages, selects one of four fixed symbols, and clears the disparity.

Input and output are valid/ready streams with a single output register between them. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the symbol is held unchanged, and the input is stalled with no effect on the disparity. The downstream serializer normally keeps `out_ready` high, so that one symbol leaves per pixel clock.

Top module: `tmds_chan_enc`

## Requirements
- R1: For a pixel beat, the XNOR chain is used when the byte has more than four ones, or exactly four ones with bit 0 equal to 0. In that case symbol bit 8 is 0. Otherwise the XOR chain is used and bit 8 is 1.
- R2: Intermediate bit 0 equals data bit 0, and intermediate bit i (1..7) equals intermediate bit i-1 XOR data bit i (XOR chain) or its complement (XNOR chain). The data is therefore recovered from a symbol as follows: complement bits 7..0 if bit 9 is 1, then take d0 = s0 and di = si XOR s(i-1), complemented when bit 8 is 0.
- R3: When the disparity before the beat is zero, or the intermediate low byte has exactly four ones, bit 9 is the complement of bit 8. In that case the low byte is complemented exactly when bit 8 is 0.
- R4: In all other pixel cases, the low byte is complemented, and bit 9 is set, when the disparity is positive with more ones than zeros in the intermediate byte, or negative with more zeros than ones.
- R5: The disparity is a signed counter that always holds an even value. In the R3 case it adds (zeros − ones) of the intermediate byte when bit 8 is 0, and (ones − zeros) when bit 8 is 1. With inversion it adds 2·bit8 + (zeros − ones). Without inversion it adds (ones − zeros) − 2·(1 − bit8).
- R6: A control beat (`in_de` = 0) emits, written bit 9 first: 00 → 1101010100, 01 → 0010101011, 10 → 0101010100, 11 → 1010101011. It also returns the disparity to zero.
- R7: An accepted beat appears on `out_sym` with `out_valid` high after exactly one clock edge. Reset clears `out_valid` and the disparity.
- R8: While `out_valid` is high and `out_ready` is low, `out_sym` and `out_valid` hold, and `in_ready` is low.
- R9: A beat offered while `in_ready` is low is not taken, and it does not move the disparity. The disparity advances once, when the beat is finally accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Encoder can take a beat this cycle |
| in_de | input | 1 | 1 = pixel byte, 0 = control value |
| in_data | input | 8 | Pixel byte |
| in_ctrl | input | 2 | Control value used when `in_de` is 0 |
| out_valid | output | 1 | Symbol register holds a symbol |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | 10 | Encoded symbol, bit 0 sent first |

## Verification
Every byte value is encoded from zero disparity. This covers the popcount boundary of exactly four ones, with bit 0 both 0 and 1. A wrong tie-break there would flip bit 8 and corrupt the recovered data. A long unbroken stream drives the disparity through positive and negative values, so a wrong inversion rule or a wrong ±2 correction shows up as a mismatched bit 9 or low byte a few symbols later. A mid-stream reset catches a disparity register that does not clear. Stalls with a beat waiting would expose a design that advances the disparity twice, or that changes the held symbol.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int BYTE_W = 8;
  localparam int QM_W   = BYTE_W + 1;
  localparam int SYM_W  = BYTE_W + 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [QM_W-1:0]  qm_t;

  function automatic logic [CNT_W-1:0] ones8(input logic [BYTE_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic sym_t ctrl_word(input logic [1:0] c);
    sym_t w;
    case (c)
      2'b00:   w = 10'b1101010100;
      2'b01:   w = 10'b0010101011;
      2'b10:   w = 10'b0101010100;
      default: w = 10'b1010101011;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tmds_chain.sv
module tmds_chain
  import tmds_enc_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  output qm_t               qm
);
  logic [CNT_W-1:0] n1;
  logic             use_xnor;

  assign n1       = ones8(data);
  assign use_xnor = (n1 > CNT_W'(BYTE_W/2)) ||
                    ((n1 == CNT_W'(BYTE_W/2)) && !data[0]);

  always_comb begin
    qm[0] = data[0];
    for (int i = 1; i < BYTE_W; i++)
      qm[i] = use_xnor ? ~(qm[i-1] ^ data[i]) : (qm[i-1] ^ data[i]);
    qm[BYTE_W] = ~use_xnor;
  end
endmodule

// File: rtl/tmds_balance.sv
module tmds_balance
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 5
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     de,
  input  qm_t                      qm,
  output sym_t                     sym,
  output logic signed [DISP_W-1:0] disp
);
  localparam logic signed [DISP_W-1:0] K_BYTE = DISP_W'(BYTE_W);
  localparam logic signed [DISP_W-1:0] K_TWO  = DISP_W'(2);

  logic [CNT_W-1:0]          n1q;
  logic signed [DISP_W-1:0]  ones_s, o_m_z, z_m_o, disp_nx;
  logic                      even, invert;

  assign n1q    = ones8(qm[BYTE_W-1:0]);
  assign ones_s = DISP_W'(n1q);
  assign o_m_z  = ones_s + ones_s - K_BYTE;
  assign z_m_o  = K_BYTE - ones_s - ones_s;
  assign even   = (disp == '0) || (n1q == CNT_W'(BYTE_W/2));
  assign invert = (!disp[DISP_W-1] && disp != '0 && n1q > CNT_W'(BYTE_W/2)) ||
                  (disp[DISP_W-1] && n1q < CNT_W'(BYTE_W/2));

  always_comb begin
    if (even) begin
      sym     = {~qm[BYTE_W], qm[BYTE_W],
                 qm[BYTE_W] ? qm[BYTE_W-1:0] : ~qm[BYTE_W-1:0]};
      disp_nx = disp + (qm[BYTE_W] ? o_m_z : z_m_o);
    end else if (invert) begin
      sym     = {1'b1, qm[BYTE_W], ~qm[BYTE_W-1:0]};
      disp_nx = disp + (qm[BYTE_W] ? K_TWO : '0) + z_m_o;
    end else begin
      sym     = {1'b0, qm[BYTE_W], qm[BYTE_W-1:0]};
      disp_nx = disp - (qm[BYTE_W] ? '0 : K_TWO) + o_m_z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   disp <= '0;
    else if (adv) disp <= de ? disp_nx : '0;
  end

  p_disp_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp[0] == 1'b0);
  p_hold_disp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(disp));
endmodule

// File: rtl/tmds_chan_enc.sv
module tmds_chan_enc
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_de,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [1:0]        in_ctrl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  out_sym
);
  qm_t                      qm;
  sym_t                     pix_sym;
  logic signed [DISP_W-1:0] disp;
  logic                     take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  tmds_chain u_chain (.data(in_data), .qm(qm));

  tmds_balance #(.DISP_W(DISP_W)) u_bal (
    .clk(clk), .rst_n(rst_n), .adv(take), .de(in_de),
    .qm(qm), .sym(pix_sym), .disp(disp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_sym <= in_de ? pix_sym : ctrl_word(in_ctrl);
    end
  end

  p_chain_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_de && ones8(in_data) > CNT_W'(BYTE_W/2)) |=> !out_sym[BYTE_W]);
  p_balanced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_de && disp == '0) |=> (out_sym[SYM_W-1] != out_sym[BYTE_W]));
  p_ctrl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_de) |=> (disp == '0));
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));
endmodule

// File: tb/tmds_chan_enc_test.sv
module tmds_chan_enc_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_de = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic [1:0] in_ctrl = '0;
  logic       in_ready, out_valid;
  logic [9:0] out_sym;

  int errors = 0, checks = 0, mdisp = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tmds_chan_enc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_de(in_de), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym));

  task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic int pop(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  task automatic model(input logic de, input logic [7:0] d, input logic [1:0] c,
                       output logic [9:0] s);
    logic [8:0] q;
    int n1, nq;
    if (!de) begin
      case (c)
        2'b00: s = 10'b1101010100;
        2'b01: s = 10'b0010101011;
        2'b10: s = 10'b0101010100;
        default: s = 10'b1010101011;
      endcase
      mdisp = 0;
      return;
    end
    n1 = pop(d);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = d[i] ^ q[i-1];
    q[8] = 1'b1;
    if (n1 > 4 || (n1 == 4 && !d[0])) begin
      for (int i = 1; i < 8; i++) q[i] = ~(d[i] ^ q[i-1]);
      q[8] = 1'b0;
    end
    nq = pop(q[7:0]);
    if (mdisp == 0 || nq == 4) begin
      s = {~q[8], q[8], q[8] ? q[7:0] : ~q[7:0]};
      mdisp += q[8] ? (2*nq - 8) : (8 - 2*nq);
    end else if ((mdisp > 0 && nq > 4) || (mdisp < 0 && nq < 4)) begin
      s = {1'b1, q[8], ~q[7:0]};
      mdisp += 2*q[8] + (8 - 2*nq);
    end else begin
      s = {1'b0, q[8], q[7:0]};
      mdisp += (2*nq - 8) - 2*(1 - q[8]);
    end
  endtask

  function automatic logic [7:0] decode(input logic [9:0] s);
    logic [7:0] b, d;
    b = s[9] ? ~s[7:0] : s[7:0];
    d[0] = b[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (b[i] ^ b[i-1]) : ~(b[i] ^ b[i-1]);
    return d;
  endfunction

  task automatic send(input logic de, input logic [7:0] d, input logic [1:0] c,
                      input string req);
    logic [9:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_de = de; in_data = d; in_ctrl = c; out_ready = 1'b1;
    model(de, d, c, e);
    @(posedge clk); #1;
    chk("R7 valid", {9'b0, out_valid}, 10'd1);
    chk(req, out_sym, e);
    if (de) chk("R2 decode", {2'b0, decode(out_sym)}, {2'b0, d});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] sa, sb;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset valid", {9'b0, out_valid}, 10'd0);
    chk("R8 ready empty", {9'b0, in_ready}, 10'd1);
    @(negedge clk); rst_n = 1'b1;

    // R6 all control words
    for (int c = 0; c < 4; c++) send(1'b0, 8'h00, 2'(c), "R6 control word");

    // R1 R2 R3 every byte from zero disparity
    for (int b = 0; b < 256; b++) begin
      send(1'b0, 8'h00, 2'b00, "R6 clear");
      send(1'b1, 8'(b), 2'b00, "R1 R3 byte sweep");
    end

    // R4 R5 long stream through varying disparity
    for (int i = 0; i < 600; i++)
      send(1'b1, 8'((i * 37 + (i >> 3) * 91 + 5) & 255), 2'b00, "R4 R5 stream");
    for (int i = 0; i < 64; i++)
      send(1'b1, (i[0] ? 8'hFF : 8'h0F), 2'b00, "R4 R5 biased stream");

    // R7 reset clears disparity mid-stream
    send(1'b1, 8'h00, 2'b00, "R5 pre-reset");
    send(1'b1, 8'h00, 2'b00, "R5 pre-reset");
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    #1;
    chk("R7 reset valid", {9'b0, out_valid}, 10'd0);
    @(negedge clk); rst_n = 1'b1; mdisp = 0;
    send(1'b1, 8'h00, 2'b00, "R7 disparity after reset");

    // R7 idle drops valid
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R7 idle", {9'b0, out_valid}, 10'd0);

    // R8 R9 back-pressure
    send(1'b1, 8'h3C, 2'b00, "R8 first beat");
    sa = out_sym;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_de = 1'b1; in_data = 8'hE1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R8 ready low", {9'b0, in_ready}, 10'd0);
      chk("R8 hold", out_sym, sa);
      chk("R8 valid hold", {9'b0, out_valid}, 10'd1);
    end
    @(negedge clk); out_ready = 1'b1;
    model(1'b1, 8'hE1, 2'b00, sb);
    @(posedge clk); #1;
    chk("R9 single advance", out_sym, sb);
    send(1'b1, 8'hE1, 2'b00, "R9 follow-on");

    @(negedge clk); in_valid = 1'b0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule